// File: doc/BRIEF.md
# SPI Status Flag Unit

This block holds the status and interrupt flags of an SPI peripheral. The SPI core reports what happens on the bus as single-cycle event pulses: a transfer finished, a receive overrun, a multi-master mode fault, and one pulse per bit shifted. It also supplies the level of the slave-select line and a transmit-busy level. A control register supplies the peripheral enable, the slave/master mode, a software interrupt-request bit and the programmed character length. The block turns all of this into one 8-bit status word, which software reads and clears through a simple write port, and into a level-sensitive interrupt line.

The block also detects a slave-mode abort. While slave select is asserted (low), it counts shifted bits modulo the character length. If slave select is released while a character is only partly shifted, the block raises the abort flag and the interrupt flag together. While the peripheral is disabled, every flag is held at its reset value and all events are ignored.

Top module: `spi_flag_unit`

## Requirements
- R1: `rd_data` bit layout is: bit 7 interrupt flag, bit 6 overrun, bit 5 collision/mode fault, bit 4 slave abort, bits 3:2 always 0, bit 1 transmit busy, bit 0 slave-select level.
- R2: After a synchronous reset, `rd_data` reads 8'h01 on the cycle after the reset edge.
- R3: A `wr_en` cycle with `wr_data` bit n = 1 (n = 7..4) clears status bit n at the next edge. A 0 in that position leaves the bit unchanged.
- R4: While `en` is 0, `rd_data` reads 8'h01 after each edge, and no event, request or write changes it.
- R5: With `en` = 1, the interrupt flag sets at the edge on which `xfer_done` is 1 or `sw_irq_req` is 1.
- R6: With `en` = 1, `overrun_evt` sets bit 6 and `fault_evt` sets bit 5 at the same edge.
- R7: In slave mode, when `ss_n` rises while the count of bits shifted in the current character is non-zero, bits 4 and 7 both set at that edge.
- R8: No abort is raised when `ss_n` rises on a character boundary, or while `slave_mode` is 0. A `char_len` of 0 selects 8 bits per character, and values 1 to 7 select that many bits. The bit count reloads to 0 on each falling edge of `ss_n`.
- R9: With `en` = 1, bit 1 equals the value `tx_busy_in` had at the previous edge, and bit 0 equals the value `ss_n` had at the previous edge.
- R10: When a set event and a write-1 clear hit the same flag in one cycle, the flag ends up set.
- R11: `irq` always equals status bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Peripheral enable from the control register |
| slave_mode | input | 1 | 1 = slave, 0 = master |
| sw_irq_req | input | 1 | Software interrupt-request control bit |
| char_len | input | 3 | Bits per character, 0 means 8 |
| xfer_done | input | 1 | Pulse: transaction completed |
| overrun_evt | input | 1 | Pulse: receive overrun |
| fault_evt | input | 1 | Pulse: multi-master mode fault |
| tx_busy_in | input | 1 | Level: transmission in progress |
| ss_n | input | 1 | Slave-select level, active low |
| bit_tick | input | 1 | Pulse: one bit shifted |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 8 | Write data, 1 clears a flag |
| rd_data | output | 8 | Status word |
| irq | output | 1 | Interrupt request level |

## Verification
The hardest case to reach is the abort. Slave mode must be selected, slave select must fall, and the exact number of bit pulses must follow so that the count sits strictly between character boundaries, all before slave select rises. Directed sequences drive this case with a 3-bit character that is cut off after two bits. A full 8-bit character (length code 0) and a master-mode release serve as negative cases. Random stimulus then toggles slave select at a low rate and emits bit pulses densely, so both partial and complete characters occur under shifting lengths and modes. A bench model compares every cycle against the requirements.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;

    localparam int STAT_W    = 8;
    localparam int LEN_W     = 3;
    localparam int CNT_W     = LEN_W + 1;
    localparam int NUM_FLAGS = 4;

    // flag vector index order matches status bits 7..4
    localparam int F_ABT = 0;
    localparam int F_COL = 1;
    localparam int F_OVR = 2;
    localparam int F_IRQ = 3;
    localparam int FLAG_LSB = 4;

    typedef struct packed {
        logic       irq;
        logic       ovr;
        logic       col;
        logic       abt;
        logic [1:0] rsvd;
        logic       tx_busy;
        logic       ss_lvl;
    } stat_word_t;

    typedef struct packed {
        logic done;
        logic ovr;
        logic fault;
        logic abort;
        logic sw;
    } evt_t;

    localparam stat_word_t STAT_RESET = '{irq: 1'b0, ovr: 1'b0, col: 1'b0, abt: 1'b0,
                                          rsvd: 2'b00, tx_busy: 1'b0, ss_lvl: 1'b1};

    // bits per character: 0 encodes the full 2**LEN_W
    function automatic logic [CNT_W-1:0] char_bits(input logic [LEN_W-1:0] len);
        return (len == '0) ? CNT_W'(1 << LEN_W) : CNT_W'(len);
    endfunction

    // map event group onto the per-flag set vector
    function automatic logic [NUM_FLAGS-1:0] flag_sets(input evt_t e);
        logic [NUM_FLAGS-1:0] s;
        s        = '0;
        s[F_IRQ] = e.sw | e.done | e.abort;
        s[F_OVR] = e.ovr;
        s[F_COL] = e.fault;
        s[F_ABT] = e.abort;
        return s;
    endfunction

    function automatic stat_word_t pack_status(input logic [NUM_FLAGS-1:0] f,
                                               input logic tx, input logic ss);
        stat_word_t w;
        w.irq     = f[F_IRQ];
        w.ovr     = f[F_OVR];
        w.col     = f[F_COL];
        w.abt     = f[F_ABT];
        w.rsvd    = 2'b00;
        w.tx_busy = tx;
        w.ss_lvl  = ss;
        return w;
    endfunction

endpackage

// File: rtl/spi_w1c_cell.sv
module spi_w1c_cell (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst || !en)
            q <= 1'b0;
        else
            q <= set | (q & ~clr);   // set has priority over clear
    end
endmodule

// File: rtl/spi_flag_bank.sv
module spi_flag_bank #(
    parameter int N = spi_flag_pkg::NUM_FLAGS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        spi_w1c_cell u_cell (
            .clk (clk),
            .rst (rst),
            .en  (en),
            .set (set[i]),
            .clr (clr[i]),
            .q   (q[i])
        );
    end
endmodule

// File: rtl/spi_abort_det.sv
module spi_abort_det
    import spi_flag_pkg::*;
#(
    parameter int LW = LEN_W,
    localparam int CW = LW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          slave_mode,
    input  logic [LW-1:0] char_len,
    input  logic          ss_n,
    input  logic          bit_tick,
    output logic          abort_pulse,
    output logic          ss_lvl
);
    logic          ss_prev_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_inc;
    logic [CW-1:0] limit;
    logic          ss_fall;
    logic          ss_rise;

    assign limit   = CW'(char_bits(LEN_W'(char_len)));
    assign ss_fall = ~ss_n & ss_prev_q;
    assign ss_rise = ss_n & ~ss_prev_q;
    assign cnt_inc = cnt_q + CW'(1);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            ss_prev_q <= 1'b1;
            cnt_q     <= '0;
        end else begin
            ss_prev_q <= ss_n;
            if (ss_fall)
                cnt_q <= '0;
            else if (!ss_n && bit_tick)
                cnt_q <= (cnt_inc >= limit) ? '0 : cnt_inc;
        end
    end

    assign abort_pulse = en & slave_mode & ss_rise & (cnt_q != '0);
    assign ss_lvl      = ss_prev_q;
endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit
    import spi_flag_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       slave_mode,
    input  logic       sw_irq_req,
    input  logic [2:0] char_len,
    input  logic       xfer_done,
    input  logic       overrun_evt,
    input  logic       fault_evt,
    input  logic       tx_busy_in,
    input  logic       ss_n,
    input  logic       bit_tick,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       irq
);
    evt_t                 evt;
    logic                 abort_pulse;
    logic                 ss_lvl;
    logic                 tx_q;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_clr;
    logic [NUM_FLAGS-1:0] flag_q;
    stat_word_t           stat;

    spi_abort_det #(.LW(LEN_W)) u_abort (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .slave_mode  (slave_mode),
        .char_len    (char_len),
        .ss_n        (ss_n),
        .bit_tick    (bit_tick),
        .abort_pulse (abort_pulse),
        .ss_lvl      (ss_lvl)
    );

    always_comb begin
        evt.done  = xfer_done;
        evt.ovr   = overrun_evt;
        evt.fault = fault_evt;
        evt.abort = abort_pulse;
        evt.sw    = sw_irq_req;
        flag_set  = flag_sets(evt);
        flag_clr  = wr_en ? wr_data[FLAG_LSB +: NUM_FLAGS] : '0;
    end

    spi_flag_bank #(.N(NUM_FLAGS)) u_bank (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .set (flag_set),
        .clr (flag_clr),
        .q   (flag_q)
    );

    always_ff @(posedge clk) begin
        if (rst || !en)
            tx_q <= 1'b0;
        else
            tx_q <= tx_busy_in;
    end

    assign stat    = pack_status(flag_q, tx_q, ss_lvl);
    assign rd_data = stat;
    assign irq     = flag_q[F_IRQ];
endmodule

// File: rtl/spi_flag_unit_chk.sv
module spi_flag_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       slave_mode,
    input logic       xfer_done,
    input logic       overrun_evt,
    input logic       fault_evt,
    input logic       tx_busy_in,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       irq
);
    assert_reset_val_R2: assert property (@(posedge clk) rst |=> rd_data == 8'h01);

    assert_disabled_R4: assert property (@(posedge clk) disable iff (rst)
        !en |=> rd_data == 8'h01);

    assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (rst)
        rd_data[3:2] == 2'b00);

    assert_irq_level_R11: assert property (@(posedge clk) disable iff (rst)
        irq == rd_data[7]);

    assert_done_sets_R5: assert property (@(posedge clk) disable iff (rst)
        en && xfer_done |=> rd_data[7]);

    assert_ovr_sets_R6: assert property (@(posedge clk) disable iff (rst)
        en && overrun_evt |=> rd_data[6]);

    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (rst)
        en && wr_en && wr_data[6] && !overrun_evt |=> !rd_data[6]);

    assert_zero_keeps_R3: assert property (@(posedge clk) disable iff (rst)
        en && rd_data[5] && !(wr_en && wr_data[5]) |=> rd_data[5]);

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
        en && fault_evt && wr_en && wr_data[5] |=> rd_data[5]);

    assert_abort_irq_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_data[4]) |-> rd_data[7]);

    assert_no_master_abort_R8: assert property (@(posedge clk) disable iff (rst)
        en && !slave_mode && !rd_data[4] |=> !rd_data[4]);

    assert_tx_mirror_R9: assert property (@(posedge clk) disable iff (rst)
        en |=> rd_data[1] == $past(tx_busy_in));
endmodule

bind spi_flag_unit spi_flag_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .slave_mode  (slave_mode),
    .xfer_done   (xfer_done),
    .overrun_evt (overrun_evt),
    .fault_evt   (fault_evt),
    .tx_busy_in  (tx_busy_in),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .irq         (irq)
);

// File: tb/sim_spi_flag_unit.sv
module sim_spi_flag_unit;
    logic       clk = 1'b0;
    logic       rst, en, slave_mode, sw_irq_req;
    logic [2:0] char_len;
    logic       xfer_done, overrun_evt, fault_evt, tx_busy_in, ss_n, bit_tick, wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done_flag = 0;

    // requirement-level model state
    logic [3:0] m_flags;
    logic       m_tx, m_ss, m_prev;
    logic [3:0] m_cnt;

    always #10ns clk = ~clk;   // 50 MHz

    spi_flag_unit u0 (
        .clk(clk), .rst(rst), .en(en), .slave_mode(slave_mode), .sw_irq_req(sw_irq_req),
        .char_len(char_len), .xfer_done(xfer_done), .overrun_evt(overrun_evt),
        .fault_evt(fault_evt), .tx_busy_in(tx_busy_in), .ss_n(ss_n), .bit_tick(bit_tick),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [3:0] len_bits(input logic [2:0] c);
        return (c == 3'd0) ? 4'd8 : {1'b0, c};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        logic rise, fall, abort;
        logic [3:0] clr, set, inc;
        if (rst || !en) begin
            m_flags = 4'h0; m_tx = 1'b0; m_ss = 1'b1; m_prev = 1'b1; m_cnt = 4'd0;
        end else begin
            rise  = ss_n & ~m_prev;
            fall  = ~ss_n & m_prev;
            abort = slave_mode & rise & (m_cnt != 4'd0);
            set   = {sw_irq_req | xfer_done | abort, overrun_evt, fault_evt, abort};
            clr   = wr_en ? wr_data[7:4] : 4'h0;
            m_flags = set | (m_flags & ~clr);
            inc = m_cnt + 4'd1;
            if (fall) m_cnt = 4'd0;
            else if (!ss_n && bit_tick) m_cnt = (inc >= len_bits(char_len)) ? 4'd0 : inc;
            m_tx = tx_busy_in; m_ss = ss_n; m_prev = ss_n;
        end
    endtask

    // one clock: model, edge, compare full word (R1) and irq level (R11)
    task automatic step();
        logic [7:0] exp;
        model_edge();
        @(posedge clk);
        @(negedge clk);
        exp = {m_flags, 2'b00, m_tx, m_ss};
        chk("R1 word", rd_data, exp);
        chk("R11 irq", {7'd0, irq}, {7'd0, exp[7]});
        xfer_done = 0; overrun_evt = 0; fault_evt = 0; bit_tick = 0; wr_en = 0; wr_data = 0;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1; wr_data = d; step();
    endtask

    initial begin
        #(20ns * 150000);
        if (!done_flag) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240917));
        rst = 1; en = 0; slave_mode = 0; sw_irq_req = 0; char_len = 3'd0;
        xfer_done = 0; overrun_evt = 0; fault_evt = 0; tx_busy_in = 0; ss_n = 1;
        bit_tick = 0; wr_en = 0; wr_data = 0;
        @(negedge clk);
        step();
        chk("R2 reset", rd_data, 8'h01);
        rst = 0;

        // R4: disabled ignores everything
        sw_irq_req = 1; xfer_done = 1; overrun_evt = 1; fault_evt = 1; tx_busy_in = 1; ss_n = 0;
        step();
        chk("R4 disabled", rd_data, 8'h01);
        sw_irq_req = 0; tx_busy_in = 0; ss_n = 1;

        // R5: software request
        en = 1; step();
        sw_irq_req = 1; step();
        chk("R5 sw irq", rd_data, 8'h81);
        chk("R11 irq pin", {7'd0, irq}, 8'h01);
        wr(8'h80);                              // R10: held request wins over clear
        chk("R10 held sw", rd_data, 8'h81);
        sw_irq_req = 0;
        wr(8'h80);
        chk("R3 clear irq", rd_data, 8'h01);
        xfer_done = 1; step();
        chk("R5 done", rd_data, 8'h81);
        wr(8'h80);

        // R6 and R3
        overrun_evt = 1; fault_evt = 1; step();
        chk("R6 ovr col", rd_data, 8'h61);
        wr(8'h00);
        chk("R3 write zero", rd_data, 8'h61);
        wr(8'h40);
        chk("R3 clear ovr", rd_data, 8'h21);
        fault_evt = 1; wr(8'h20);
        chk("R10 set wins", rd_data, 8'h21);
        wr(8'hF0);
        chk("R3 clear all", rd_data, 8'h01);

        // R9 mirrors
        tx_busy_in = 1; ss_n = 0; step();
        chk("R9 tx ss", rd_data, 8'h02);
        tx_busy_in = 0; ss_n = 1; step();

        // R7: 3-bit character cut after two bits
        slave_mode = 1; char_len = 3'd3;
        ss_n = 0; step();
        bit_tick = 1; step();
        bit_tick = 1; step();
        ss_n = 1; step();
        chk("R7 abort", rd_data, 8'h91);
        wr(8'h90);

        // R8: full 8-bit character, no abort
        char_len = 3'd0; ss_n = 0; step();
        for (int i = 0; i < 8; i++) begin bit_tick = 1; step(); end
        ss_n = 1; step();
        chk("R8 full char", rd_data, 8'h01);
        // R8: master mode partial, no abort
        slave_mode = 0; ss_n = 0; step();
        bit_tick = 1; step();
        ss_n = 1; step();
        chk("R8 master", rd_data, 8'h01);

        // R4: disable clears set flags
        overrun_evt = 1; xfer_done = 1; step();
        en = 0; step();
        chk("R4 disable clears", rd_data, 8'h01);
        en = 1; step();

        // random phase, every cycle compared against the model (R1..R11)
        for (int n = 0; n < 4000; n++) begin
            en          = ($urandom % 40) != 0;
            rst         = ($urandom % 500) == 0;
            if (($urandom % 50) == 0) slave_mode = $urandom;
            if (($urandom % 60) == 0) char_len = 3'($urandom);
            sw_irq_req  = ($urandom % 30) == 0;
            xfer_done   = ($urandom % 12) == 0;
            overrun_evt = ($urandom % 15) == 0;
            fault_evt   = ($urandom % 20) == 0;
            tx_busy_in  = ($urandom % 3) != 0;
            if (($urandom % 7) == 0) ss_n = ~ss_n;
            bit_tick    = ($urandom % 2) == 0;
            wr_en       = ($urandom % 5) == 0;
            wr_data     = 8'($urandom);
            step();
        end
        rst = 0;

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule